// File: doc/BRIEF.md
# Dual-Buffer CAN Receive Commit Controller

This block sits behind a CAN bit-stream decoder and its identifier comparators. When the assembly stage signals that a frame is complete, or that an error cut a frame short, the block decides which of two receive buffers takes the frame. It then copies the frame into that buffer and raises the buffer's full flag. The host reads the buffer and clears the flag to release it.

Buffer 0 is the high-priority slot and is fed by a group of two acceptance filters. Buffer 1 is the low-priority slot and is fed by a group of four. Each buffer has a 2-bit receive mode:

- **Filtered:** filters qualify the frame, and each filter's extended-enable bit must equal the frame's identifier type.
- **Standard only:** filtered, and extended frames are rejected.
- **Extended only:** filtered, and standard frames are rejected.
- **Accept all:** the filters are bypassed. A frame cut short by an error is still stored.

Rollover is optional. When it is on and buffer 0 is full, a frame that buffer 0 would have taken goes to buffer 1.

A four-state machine controls the commit:

- **IDLE** waits for a strobe. On a strobe it latches the frame into a hold register and picks the next state.
- **LOAD0** writes the hold register into buffer 0.
- **LOAD1** writes the hold register into buffer 1.
- **DROP** sets the overflow flag.

The transitions are:

- IDLE→LOAD0 when buffer 0 accepts the frame and is free.
- IDLE→LOAD1 on a rollover, or when buffer 1 accepts the frame and is free.
- IDLE→DROP when some buffer accepts the frame but no eligible buffer is free.
- IDLE→IDLE when no buffer accepts the frame.
- LOAD0, LOAD1 and DROP always return to IDLE.

Top module: `canrx_commit`

## Requirements
- R1: A load overwrites every stored field of the target buffer (identifier, extended flag, remote flag, length, all data bytes, hit code) with the captured frame, whatever its identifier type or length. A frame presented with a strobe in cycle T appears at the buffer outputs after the second rising edge from T. Strobes that arrive while the state machine is not in IDLE are ignored.
- R2: The full flag of a buffer rises on the same edge as its load. A buffer whose flag is set is never written. Only clr_full clears the flag.
- R3: When both filter groups accept a frame, buffer 0 takes it. The 4-bit hit code is the lowest passing filter index: filters 0–1 of group 0 give codes 0–1, and filters 0–3 of group 1 give codes 2–5. Code 15 means that no filter passed and the frame was taken through accept-all mode.
- R4: With roll_en high and buffer 0 full, a frame that buffer 0 accepts is loaded into buffer 1 with buffer 0's hit code, whatever buffer 1's filters say, and the overflow flag is not raised.
- R5: Mode encodings are 00 filtered, 01 standard only, 10 extended only. In these modes a filter passes when its match bit is 1 and its extended-enable bit equals frm_ext; in mode 01 an extended frame never passes, and in mode 10 a standard frame never passes.
- R6: Mode 11 accepts every valid frame without regard to the filters. On frm_abort, only a buffer in mode 11 accepts, and it stores the fields as presented. frm_abort is ignored by buffers in other modes.
- R7: The stored remote and extended flags equal frm_rtr and frm_ext of the loaded frame.
- R8: irq pulses high for one cycle on the edge that loads a complete frame while irq_en is high. It stays low for partial frames stored after an abort, and it stays low when irq_en is low.
- R9: A frame that some buffer accepts but that no eligible free buffer can take is dropped and sets ovf. ovf stays set until clr_ovf. A drop changes no buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Complete-frame strobe |
| frm_abort | input | 1 | Error-abort strobe; ignored when frm_valid is high |
| frm_id | input | ID_W | Assembled identifier |
| frm_ext | input | 1 | 1 = extended identifier |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 8*DATA_BYTES | Assembled data bytes |
| grp0_hit | input | NF0 | Match bits of buffer 0's filters |
| grp0_xen | input | NF0 | Extended-enable bits of buffer 0's filters |
| grp1_hit | input | NF1 | Match bits of buffer 1's filters |
| grp1_xen | input | NF1 | Extended-enable bits of buffer 1's filters |
| rx_mode0 | input | 2 | Receive mode of buffer 0 |
| rx_mode1 | input | 2 | Receive mode of buffer 1 |
| roll_en | input | 1 | Rollover enable |
| irq_en | input | 1 | Receive interrupt enable |
| clr_full | input | 2 | Host release of each buffer |
| clr_ovf | input | 1 | Host clear of ovf |
| b0_id | output | ID_W | Buffer 0 identifier |
| b0_ext | output | 1 | Buffer 0 extended flag |
| b0_rtr | output | 1 | Buffer 0 remote flag |
| b0_dlc | output | 4 | Buffer 0 length |
| b0_data | output | 8*DATA_BYTES | Buffer 0 data |
| b0_hit | output | 4 | Buffer 0 hit code |
| b1_id | output | ID_W | Buffer 1 identifier |
| b1_ext | output | 1 | Buffer 1 extended flag |
| b1_rtr | output | 1 | Buffer 1 remote flag |
| b1_dlc | output | 4 | Buffer 1 length |
| b1_data | output | 8*DATA_BYTES | Buffer 1 data |
| b1_hit | output | 4 | Buffer 1 hit code |
| full | output | 2 | Full flag of each buffer |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Filter type does not match the frame type.** A design that ignored the extended-enable bit would load a standard frame through an extended filter.
- **Mode 01 or 10 with a passing filter.** A design that ignored these modes would accept identifiers of the wrong type.
- **Both filter groups match.** A design with inverted priority would fill buffer 1 and report a code of 2 or above.
- **Rollover with buffer 1 full, and a locked buffer 0 with rollover off.** A missing lockout would overwrite stored data. A missing drop path would leave ovf low.
- **A long extended frame followed by a zero-length standard frame.** A partial copy would leave stale bytes from the first frame.
- **Abort strobes in filtered and accept-all modes.** These show whether partial frames are stored only where allowed, and whether they wrongly raise irq.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    localparam int HIT_W = 4;
    localparam logic [HIT_W-1:0] HIT_NONE = 4'hF;

    typedef enum logic [1:0] {
        RXM_FILT = 2'b00,
        RXM_STD  = 2'b01,
        RXM_EXT  = 2'b10,
        RXM_ALL  = 2'b11
    } rxm_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD0 = 2'd1,
        ST_LOAD1 = 2'd2,
        ST_DROP  = 2'd3
    } cst_e;

endpackage

// File: rtl/canrx_qual.sv
module canrx_qual
    import canrx_pkg::*;
#(
    parameter int NF   = 2,
    parameter int BASE = 0
) (
    input  logic [NF-1:0]    hit,
    input  logic [NF-1:0]    xen,
    input  logic             ext,
    input  logic [1:0]       mode,
    output logic             acc_ok,
    output logic             acc_err,
    output logic [HIT_W-1:0] code
);

    logic [NF-1:0] pass;
    rxm_e          m;

    assign m = rxm_e'(mode);

    // per-filter qualification: match plus identifier-type agreement
    always_comb begin
        for (int i = 0; i < NF; i++) begin
            pass[i] = hit[i] && (xen[i] == ext);
        end
        unique case (m)
            RXM_STD: if (ext)  pass = '0;
            RXM_EXT: if (!ext) pass = '0;
            default: ;
        endcase
    end

    // lowest passing index wins the code
    always_comb begin
        code = HIT_NONE;
        for (int i = NF - 1; i >= 0; i--) begin
            if (pass[i]) code = HIT_W'(BASE + i);
        end
    end

    assign acc_ok  = (|pass) || (m == RXM_ALL);
    assign acc_err = (m == RXM_ALL);

endmodule

// File: rtl/canrx_slot.sv
module canrx_slot
    import canrx_pkg::*;
#(
    parameter int ID_W = 29,
    parameter int DW   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             clr,
    input  logic [ID_W-1:0]  id_i,
    input  logic             ext_i,
    input  logic             rtr_i,
    input  logic [3:0]       dlc_i,
    input  logic [DW-1:0]    data_i,
    input  logic [HIT_W-1:0] hit_i,
    output logic             full_o,
    output logic [ID_W-1:0]  id_o,
    output logic             ext_o,
    output logic             rtr_o,
    output logic [3:0]       dlc_o,
    output logic [DW-1:0]    data_o,
    output logic [HIT_W-1:0] hit_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_o <= 1'b0;
        end else if (wr) begin
            full_o <= 1'b1;
        end else if (clr) begin
            full_o <= 1'b0;
        end
    end

    // whole-record overwrite on every load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_o   <= '0;
            ext_o  <= 1'b0;
            rtr_o  <= 1'b0;
            dlc_o  <= '0;
            data_o <= '0;
            hit_o  <= '0;
        end else if (wr) begin
            id_o   <= id_i;
            ext_o  <= ext_i;
            rtr_o  <= rtr_i;
            dlc_o  <= dlc_i;
            data_o <= data_i;
            hit_o  <= hit_i;
        end
    end

endmodule

// File: rtl/canrx_commit.sv
module canrx_commit
    import canrx_pkg::*;
#(
    parameter int ID_W       = 29,
    parameter int DATA_BYTES = 8,
    parameter int NF0        = 2,
    parameter int NF1        = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid,
    input  logic                    frm_abort,
    input  logic [ID_W-1:0]         frm_id,
    input  logic                    frm_ext,
    input  logic                    frm_rtr,
    input  logic [3:0]              frm_dlc,
    input  logic [8*DATA_BYTES-1:0] frm_data,
    input  logic [NF0-1:0]          grp0_hit,
    input  logic [NF0-1:0]          grp0_xen,
    input  logic [NF1-1:0]          grp1_hit,
    input  logic [NF1-1:0]          grp1_xen,
    input  logic [1:0]              rx_mode0,
    input  logic [1:0]              rx_mode1,
    input  logic                    roll_en,
    input  logic                    irq_en,
    input  logic [1:0]              clr_full,
    input  logic                    clr_ovf,
    output logic [ID_W-1:0]         b0_id,
    output logic                    b0_ext,
    output logic                    b0_rtr,
    output logic [3:0]              b0_dlc,
    output logic [8*DATA_BYTES-1:0] b0_data,
    output logic [3:0]              b0_hit,
    output logic [ID_W-1:0]         b1_id,
    output logic                    b1_ext,
    output logic                    b1_rtr,
    output logic [3:0]              b1_dlc,
    output logic [8*DATA_BYTES-1:0] b1_data,
    output logic [3:0]              b1_hit,
    output logic [1:0]              full,
    output logic                    ovf,
    output logic                    irq
);

    localparam int DW    = 8 * DATA_BYTES;
    localparam int BASE1 = NF0;
    localparam int NBUF  = 2;

    cst_e state, nstate;

    logic             go, a0, a1;
    logic             q0_ok, q0_err, q1_ok, q1_err;
    logic [HIT_W-1:0] c0, c1, pick_code;

    logic [ID_W-1:0]  h_id;
    logic             h_ext, h_rtr, h_err;
    logic [3:0]       h_dlc;
    logic [DW-1:0]    h_data;
    logic [HIT_W-1:0] h_code;

    logic [NBUF-1:0]  wr_en;
    logic             ovf_set;

    logic [ID_W-1:0]  s_id   [NBUF];
    logic             s_ext  [NBUF];
    logic             s_rtr  [NBUF];
    logic [3:0]       s_dlc  [NBUF];
    logic [DW-1:0]    s_data [NBUF];
    logic [HIT_W-1:0] s_hit  [NBUF];

    canrx_qual #(.NF(NF0), .BASE(0)) u_q0 (
        .hit(grp0_hit), .xen(grp0_xen), .ext(frm_ext), .mode(rx_mode0),
        .acc_ok(q0_ok), .acc_err(q0_err), .code(c0)
    );

    canrx_qual #(.NF(NF1), .BASE(BASE1)) u_q1 (
        .hit(grp1_hit), .xen(grp1_xen), .ext(frm_ext), .mode(rx_mode1),
        .acc_ok(q1_ok), .acc_err(q1_err), .code(c1)
    );

    assign go = (state == ST_IDLE) && (frm_valid || frm_abort);
    assign a0 = frm_valid ? q0_ok : q0_err;
    assign a1 = frm_valid ? q1_ok : q1_err;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // routing decision
    always_comb begin
        nstate    = state;
        pick_code = HIT_NONE;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    if (a0 && !full[0]) begin
                        nstate    = ST_LOAD0;
                        pick_code = c0;
                    end else if (a0 && roll_en) begin
                        pick_code = c0;
                        nstate    = full[1] ? ST_DROP : ST_LOAD1;
                    end else if (a1 && !full[1]) begin
                        nstate    = ST_LOAD1;
                        pick_code = c1;
                    end else if (a0 || a1) begin
                        nstate    = ST_DROP;
                    end
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        wr_en   = '0;
        ovf_set = 1'b0;
        unique case (state)
            ST_LOAD0: wr_en[0] = 1'b1;
            ST_LOAD1: wr_en[1] = 1'b1;
            ST_DROP:  ovf_set  = 1'b1;
            default:  ;
        endcase
    end

    // hold register for the captured frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_id   <= '0;
            h_ext  <= 1'b0;
            h_rtr  <= 1'b0;
            h_dlc  <= '0;
            h_data <= '0;
            h_code <= HIT_NONE;
            h_err  <= 1'b0;
        end else if (go) begin
            h_id   <= frm_id;
            h_ext  <= frm_ext;
            h_rtr  <= frm_rtr;
            h_dlc  <= frm_dlc;
            h_data <= frm_data;
            h_code <= pick_code;
            h_err  <= !frm_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (ovf_set)      ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
            irq <= (|wr_en) && irq_en && !h_err;
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        canrx_slot #(.ID_W(ID_W), .DW(DW)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr(wr_en[g]), .clr(clr_full[g]),
            .id_i(h_id), .ext_i(h_ext), .rtr_i(h_rtr), .dlc_i(h_dlc),
            .data_i(h_data), .hit_i(h_code),
            .full_o(full[g]), .id_o(s_id[g]), .ext_o(s_ext[g]),
            .rtr_o(s_rtr[g]), .dlc_o(s_dlc[g]), .data_o(s_data[g]),
            .hit_o(s_hit[g])
        );
    end

    assign b0_id   = s_id[0];
    assign b0_ext  = s_ext[0];
    assign b0_rtr  = s_rtr[0];
    assign b0_dlc  = s_dlc[0];
    assign b0_data = s_data[0];
    assign b0_hit  = s_hit[0];
    assign b1_id   = s_id[1];
    assign b1_ext  = s_ext[1];
    assign b1_rtr  = s_rtr[1];
    assign b1_dlc  = s_dlc[1];
    assign b1_data = s_data[1];
    assign b1_hit  = s_hit[1];

endmodule

// File: rtl/canrx_chk.sv
module canrx_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    full,
    input logic [1:0]    clr_full,
    input logic          ovf,
    input logic          clr_ovf,
    input logic          irq,
    input logic [3:0]    b0_hit,
    input logic [3:0]    b1_hit,
    input logic [DW-1:0] b0_data,
    input logic [DW-1:0] b1_data
);

    // R2
    full0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full[0] && !clr_full[0]) |=> full[0]);

    // R2
    full1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full[1] && !clr_full[1]) |=> full[1]);

    // R2
    lock0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full[0] |=> $stable(b0_data));

    // R2
    lock1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full[1] |=> $stable(b1_data));

    // R3
    hit0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full[0] |-> (b0_hit <= 4'd1 || b0_hit == 4'hF));

    // R3
    hit1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full[1] |-> (b1_hit <= 4'd5 || b1_hit == 4'hF));

    // R8
    irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($rose(full[0]) || $rose(full[1])));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

endmodule

bind canrx_commit canrx_chk #(.DW(8 * DATA_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .full(full), .clr_full(clr_full),
    .ovf(ovf), .clr_ovf(clr_ovf), .irq(irq),
    .b0_hit(b0_hit), .b1_hit(b1_hit), .b0_data(b0_data), .b1_data(b1_data)
);

// File: tb/sim_canrx_commit.sv
`timescale 1ns/1ps
module sim_canrx_commit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_abort = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic [1:0]  grp0_hit = '0, grp0_xen = '0;
    logic [3:0]  grp1_hit = '0, grp1_xen = '0;
    logic [1:0]  rx_mode0 = '0, rx_mode1 = '0;
    logic        roll_en = 1'b0, irq_en = 1'b0;
    logic [1:0]  clr_full = '0;
    logic        clr_ovf = 1'b0;
    logic [28:0] b0_id, b1_id;
    logic        b0_ext, b0_rtr, b1_ext, b1_rtr;
    logic [3:0]  b0_dlc, b1_dlc, b0_hit, b1_hit;
    logic [63:0] b0_data, b1_data;
    logic [1:0]  full;
    logic        ovf, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    canrx_commit u0 (.*);

    typedef struct packed {
        logic [1:0] m0;
        logic [1:0] m1;
        logic       ext;
        logic [1:0] h0;
        logic [1:0] x0;
        logic [3:0] h1;
        logic [3:0] x1;
        logic       ab;
        logic [1:0] dst;   // 0 buf0, 1 buf1, 3 none
        logic [3:0] code;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd0, 1'b0, 2'b01, 2'b00, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd0},   // R5
        '{2'd0, 2'd0, 1'b0, 2'b10, 2'b00, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd1},   // R3
        '{2'd0, 2'd0, 1'b0, 2'b01, 2'b01, 4'b0000, 4'b0000, 1'b0, 2'd3, 4'd15},  // R5
        '{2'd0, 2'd0, 1'b1, 2'b00, 2'b00, 4'b0100, 4'b0100, 1'b0, 2'd1, 4'd4},   // R3
        '{2'd0, 2'd0, 1'b0, 2'b11, 2'b00, 4'b1111, 4'b0000, 1'b0, 2'd0, 4'd0},   // R3
        '{2'd1, 2'd0, 1'b1, 2'b01, 2'b01, 4'b0000, 4'b0000, 1'b0, 2'd3, 4'd15},  // R5
        '{2'd2, 2'd0, 1'b1, 2'b10, 2'b10, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd1},   // R5
        '{2'd2, 2'd0, 1'b0, 2'b01, 2'b00, 4'b0001, 4'b0000, 1'b0, 2'd1, 4'd2},   // R5
        '{2'd3, 2'd0, 1'b0, 2'b00, 2'b00, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd15},  // R6
        '{2'd0, 2'd3, 1'b0, 2'b01, 2'b00, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd15},  // R6
        '{2'd0, 2'd0, 1'b0, 2'b01, 2'b00, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd15},  // R6
        '{2'd3, 2'd0, 1'b0, 2'b10, 2'b00, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd1},   // R3
        '{2'd0, 2'd0, 1'b0, 2'b00, 2'b00, 4'b1000, 4'b0000, 1'b0, 2'd1, 4'd5}    // R3
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic a);
        @(negedge clk);
        frm_valid = v;
        frm_abort = a;
        @(negedge clk);
        frm_valid = 1'b0;
        frm_abort = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_all();
        @(negedge clk);
        clr_full = 2'b11;
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_full = 2'b00;
        clr_ovf = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R9, R8)
        chk(full == 2'b00, "R2 reset full", 64'(full), 64'd0);
        chk(ovf == 1'b0, "R9 reset ovf", 64'(ovf), 64'd0);
        chk(irq == 1'b0, "R8 reset irq", 64'(irq), 64'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            rx_mode0 = VT[k].m0;
            rx_mode1 = VT[k].m1;
            frm_ext  = VT[k].ext;
            grp0_hit = VT[k].h0;
            grp0_xen = VT[k].x0;
            grp1_hit = VT[k].h1;
            grp1_xen = VT[k].x1;
            send(!VT[k].ab, VT[k].ab);
            if (VT[k].dst == 2'd0) begin
                chk(full == 2'b01, $sformatf("R3/R5/R6 vec%0d full", k), 64'(full), 64'd1);
                chk(b0_hit == VT[k].code, $sformatf("R3 vec%0d hit", k), 64'(b0_hit), 64'(VT[k].code));
            end else if (VT[k].dst == 2'd1) begin
                chk(full == 2'b10, $sformatf("R3/R5/R6 vec%0d full", k), 64'(full), 64'd2);
                chk(b1_hit == VT[k].code, $sformatf("R3 vec%0d hit", k), 64'(b1_hit), 64'(VT[k].code));
            end else begin
                chk(full == 2'b00 && ovf == 1'b0, $sformatf("R5/R6 vec%0d none", k),
                    64'({full, ovf}), 64'd0);
            end
            release_all();
        end
        grp1_hit = '0; grp1_xen = '0; rx_mode0 = 2'd0; rx_mode1 = 2'd0;

        // R1, R7: long extended remote frame, then short standard frame
        frm_ext = 1'b1; frm_rtr = 1'b1; frm_id = 29'h1ABCDEF0; frm_dlc = 4'd8;
        frm_data = 64'h1122334455667788; grp0_hit = 2'b01; grp0_xen = 2'b01;
        send(1'b1, 1'b0);
        chk(b0_id == 29'h1ABCDEF0, "R1 ext id", 64'(b0_id), 64'h1ABCDEF0);
        chk(b0_ext == 1'b1 && b0_rtr == 1'b1, "R7 flags set", 64'({b0_ext, b0_rtr}), 64'd3);
        release_all();
        frm_ext = 1'b0; frm_rtr = 1'b0; frm_id = 29'h123; frm_dlc = 4'd0;
        frm_data = 64'hA5A5A5A5A5A5A5A5; grp0_xen = 2'b00;
        send(1'b1, 1'b0);
        chk(b0_data == 64'hA5A5A5A5A5A5A5A5, "R1 data overwrite", b0_data, 64'hA5A5A5A5A5A5A5A5);
        chk(b0_dlc == 4'd0 && b0_id == 29'h123, "R1 dlc/id overwrite", 64'({b0_dlc, b0_id}), 64'h123);
        chk(b0_ext == 1'b0 && b0_rtr == 1'b0, "R7 flags clear", 64'({b0_ext, b0_rtr}), 64'd0);

        // R4: rollover into buffer 1 with buffer 0's code
        roll_en = 1'b1; frm_data = 64'hB0B0B0B0B0B0B0B0; grp0_hit = 2'b10;
        send(1'b1, 1'b0);
        chk(full == 2'b11 && ovf == 1'b0, "R4 rollover full", 64'({full, ovf}), 64'd6);
        chk(b1_hit == 4'd1, "R4 rollover code", 64'(b1_hit), 64'd1);
        chk(b1_data == 64'hB0B0B0B0B0B0B0B0, "R4 rollover data", b1_data, 64'hB0B0B0B0B0B0B0B0);
        chk(b0_data == 64'hA5A5A5A5A5A5A5A5, "R2 b0 kept", b0_data, 64'hA5A5A5A5A5A5A5A5);

        // R9: both full with rollover -> drop
        frm_data = 64'hC0C0C0C0C0C0C0C0; grp0_hit = 2'b01;
        send(1'b1, 1'b0);
        chk(ovf == 1'b1, "R9 drop both full", 64'(ovf), 64'd1);
        chk(b1_data == 64'hB0B0B0B0B0B0B0B0, "R9 b1 untouched", b1_data, 64'hB0B0B0B0B0B0B0B0);
        @(negedge clk);
        chk(ovf == 1'b1, "R9 sticky", 64'(ovf), 64'd1);

        // R2: host clears buffer 1 and ovf; rollover off; b0 locked
        @(negedge clk);
        clr_full = 2'b10; clr_ovf = 1'b1;
        @(negedge clk);
        clr_full = 2'b00; clr_ovf = 1'b0;
        chk(full == 2'b01 && ovf == 1'b0, "R2 host clear", 64'({full, ovf}), 64'd2);
        roll_en = 1'b0;
        send(1'b1, 1'b0);
        chk(full == 2'b01 && ovf == 1'b1, "R2 lockout drop", 64'({full, ovf}), 64'd3);
        chk(b0_data == 64'hA5A5A5A5A5A5A5A5, "R2 lockout data", b0_data, 64'hA5A5A5A5A5A5A5A5);
        release_all();

        // R8: interrupt
        irq_en = 1'b1;
        send(1'b1, 1'b0);
        chk(irq == 1'b1, "R8 irq pulse", 64'(irq), 64'd1);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq one cycle", 64'(irq), 64'd0);
        release_all();
        rx_mode0 = 2'd3;
        send(1'b0, 1'b1);
        chk(full == 2'b01 && irq == 1'b0, "R8 R6 abort load no irq", 64'({full, irq}), 64'd2);
        release_all();
        rx_mode0 = 2'd0; irq_en = 1'b0;
        send(1'b1, 1'b0);
        chk(full == 2'b01 && irq == 1'b0, "R8 irq disabled", 64'({full, irq}), 64'd2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule